// File: doc/BRIEF.md
# 10BASE-T Manchester Transmit Serializer

This block turns a stream of 4-bit transmit nibbles into a Manchester-coded serial line signal for a 10 Mb/s twisted-pair driver. It runs on a clock at twice the bit rate, so every bit cell spans two clock cycles (two half-cells). Each accepted nibble is shifted out least significant bit first. A 0 bit is coded as high then low, and a 1 bit as low then high, so every cell has a transition at its centre.

Nibbles enter on a valid/ready interface sampled on the rising clock edge. The source raises `in_valid` to start a frame and keeps `in_nibble` steady until it sees `in_ready` high at a rising edge. While idle the block is always ready. During a frame, ready is high only in the final half-cell of the current nibble, so a source that holds valid high streams nibbles with no gap. If valid is low at that point, the frame ends. The line is then held high for a tail of `TAIL_HALVES` half-cells, after which the driver enable drops and the line returns low.

Because the tail is high, the last transition of a frame lands at a cell boundary when the final bit is 0, and at the cell centre when the final bit is 1.

Top module: `mtx_manchester_tx`

## Requirements
- R1: After reset, `line_en` and `line_p` are 0 and `in_ready` is 1.
- R2: A nibble is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Its first half-cell appears on the line from the next edge. A 0 bit drives `line_p` 1 then 0; a 1 bit drives 0 then 1.
- R3: Bits leave least significant first: bit k of the nibble occupies half-cells 2k and 2k+1 after acceptance.
- R4: During a frame, `in_ready` is 1 only in the last half-cell (the eighth) of the current nibble. A nibble accepted there starts on the next edge, with no gap.
- R5: When `in_valid` is 0 at the last half-cell of a nibble, `line_p` is held 1 with `line_en` 1 for `TAIL_HALVES` (default 4) half-cells, and then the block goes idle. The final line transition is therefore at the cell boundary after a final 0 bit, and at mid-cell for a final 1 bit.
- R6: An accepted nibble is sent in full even if `in_valid` drops right after acceptance. `in_valid` and `in_nibble` have no effect while `in_ready` is 0.
- R7: While idle, `line_en` is 0, `line_p` is 0, and a low `in_valid` leaves the block idle.
- R8: A stream of all-ones nibbles makes `line_p` toggle on every half-cell for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate (one cycle per half-cell) |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Transmit enable / nibble valid |
| in_ready | output | 1 | Block accepts `in_nibble` on this edge |
| in_nibble | input | 4 | Transmit nibble, bit 0 sent first |
| line_p | output | 1 | Manchester-coded line level |
| line_en | output | 1 | Differential driver enable |

## Verification
The hardest situation to reach from the ports is the end of a frame. The frame must stop exactly at a handshake point, and the tail must then be checked against the value of the final bit. The bench walks a table of frames whose final bits are 0 in some and 1 in others. For each frame it drops valid at the last ready pulse and compares the level of the first tail half-cell with the last data half-cell. A directed case lowers valid, and scrambles the nibble, one half-cell after acceptance, to show that a one-nibble frame still completes.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_TAIL = 2'd2
  } mtx_state_e;
endpackage

// File: rtl/mtx_nibble_shifter.sv
module mtx_nibble_shifter #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NIB_W-1:0] nib,
  input  logic             active,
  output logic             cur_bit,
  output logic             half,
  output logic             nib_last
);
  localparam int CNT_W = (NIB_W > 1) ? $clog2(NIB_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(NIB_W - 1);

  logic [NIB_W-1:0] shreg;
  logic [CNT_W-1:0] bitcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      bitcnt <= '0;
      half   <= 1'b0;
    end else if (load) begin
      shreg  <= nib;
      bitcnt <= '0;
      half   <= 1'b0;
    end else if (active) begin
      half <= ~half;
      if (half && bitcnt != LAST_BIT) begin
        shreg  <= shreg >> 1;
        bitcnt <= bitcnt + 1'b1;
      end
    end
  end

  assign cur_bit  = shreg[0];
  assign nib_last = active && half && (bitcnt == LAST_BIT);

  // R3
  bit_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && half && !nib_last && !load) |=> (bitcnt == $past(bitcnt) + 1'b1));
endmodule

// File: rtl/mtx_frame_ctrl.sv
module mtx_frame_ctrl
  import mtx_pkg::*;
#(
  parameter int TAIL_HALVES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       nib_last,
  output logic       in_ready,
  output logic       load,
  output mtx_state_e state
);
  localparam int TAIL_W = $clog2(TAIL_HALVES + 1);
  localparam logic [TAIL_W-1:0] TAIL_END = TAIL_W'(TAIL_HALVES - 1);

  logic [TAIL_W-1:0] tailcnt;

  assign in_ready = (state == ST_IDLE) || nib_last;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tailcnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (load) state <= ST_DATA;
        ST_DATA: if (nib_last && !in_valid) begin
          state   <= ST_TAIL;
          tailcnt <= '0;
        end
        ST_TAIL: begin
          if (tailcnt == TAIL_END) state <= ST_IDLE;
          else tailcnt <= tailcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && load) |=> (state == ST_DATA));
  // R6
  accepted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && !in_ready) |=> (state == ST_DATA));
  // R5
  tail_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAIL && tailcnt == TAIL_END) |=> (state == ST_IDLE));
endmodule

// File: rtl/mtx_line_encoder.sv
module mtx_line_encoder
  import mtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mtx_state_e state,
  input  logic       cur_bit,
  input  logic       half,
  output logic       line_p,
  output logic       line_en
);
  always_comb begin
    line_en = (state != ST_IDLE);
    unique case (state)
      ST_DATA: line_p = half ? cur_bit : ~cur_bit;
      ST_TAIL: line_p = 1'b1;
      default: line_p = 1'b0;
    endcase
  end

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_en |-> !line_p);
  // R2
  mid_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && half && $past(state) == ST_DATA) |-> (line_p != $past(line_p)));
  // R5
  tail_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAIL) |-> (line_p && line_en));
endmodule

// File: rtl/mtx_manchester_tx.sv
module mtx_manchester_tx
  import mtx_pkg::*;
#(
  parameter int NIB_W       = 4,
  parameter int TAIL_HALVES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NIB_W-1:0] in_nibble,
  output logic             line_p,
  output logic             line_en
);
  mtx_state_e state;
  logic load, cur_bit, half, nib_last;

  mtx_frame_ctrl #(.TAIL_HALVES(TAIL_HALVES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .nib_last(nib_last),
    .in_ready(in_ready), .load(load), .state(state)
  );

  mtx_nibble_shifter #(.NIB_W(NIB_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .nib(in_nibble),
    .active(state == ST_DATA), .cur_bit(cur_bit), .half(half), .nib_last(nib_last)
  );

  mtx_line_encoder u_enc (
    .clk(clk), .rst_n(rst_n), .state(state), .cur_bit(cur_bit), .half(half),
    .line_p(line_p), .line_en(line_en)
  );
endmodule

// File: tb/mtx_manchester_tx_tb.sv
module mtx_manchester_tx_tb;
  localparam int TAIL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [3:0] in_nibble = 4'h0;
  logic in_ready, line_p, line_en;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mtx_manchester_tx #(.NIB_W(4), .TAIL_HALVES(TAIL)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_nibble(in_nibble), .line_p(line_p), .line_en(line_en)
  );

  // each vector: {count[3:0], nibbles[15:0]}, nibble i at bits 4i+3:4i
  localparam logic [19:0] VEC [6] = '{
    {4'd1, 16'h0005},  // final bit 0
    {4'd1, 16'h000A},  // final bit 1
    {4'd2, 16'h0081},
    {4'd3, 16'h0E61},
    {4'd4, 16'hFFFF},  // all ones
    {4'd2, 16'h0070}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(line_en == 1'b0, {req, " line_en"}, int'(line_en), 0);
    chk(line_p == 1'b0, {req, " line_p"}, int'(line_p), 0);
    chk(in_ready == 1'b1, {req, " in_ready"}, int'(in_ready), 1);
  endtask

  task automatic run_frame(input int n, input logic [15:0] nibs, input bit drop_early);
    logic prev;
    logic lastbit;
    bit all_ones;
    all_ones = (n == 4 && nibs == 16'hFFFF);
    @(negedge clk);
    chk_idle("R7 pre-frame");
    in_valid  = 1'b1;
    in_nibble = nibs[3:0];
    prev = 1'b0;
    for (int i = 0; i < n; i++) begin
      for (int h = 0; h < 8; h++) begin
        logic b, e;
        @(negedge clk);
        b = nibs[4*i + h/2];
        e = (h % 2 == 1) ? b : ~b;
        chk(line_p == e, "R2 R3 half-cell level", int'(line_p), int'(e));
        chk(line_en == 1'b1, "R2 line_en", int'(line_en), 1);
        chk(in_ready == (h == 7), "R4 ready timing", int'(in_ready), int'(h == 7));
        if (all_ones && !(i == 0 && h == 0))
          chk(line_p != prev, "R8 toggle each half", int'(line_p), int'(~prev));
        prev = line_p;
        if (drop_early && i == 0 && h == 0) begin
          in_valid  = 1'b0;
          in_nibble = ~nibs[3:0];
        end
        if (h == 7) begin
          if (i + 1 < n) in_nibble = nibs[4*(i+1) +: 4];
          else in_valid = 1'b0;
        end
        if (!drop_early && h == 3) in_nibble = ~in_nibble;   // R6 ignored while not ready
        if (!drop_early && h == 4) in_nibble = ~in_nibble;
      end
    end
    lastbit = nibs[4*(n-1) + 3];
    for (int t = 0; t < TAIL; t++) begin
      @(negedge clk);
      if (t == 0)
        chk((prev != line_p) == (lastbit == 1'b0), "R5 final transition position",
            int'(prev), int'(lastbit));
      chk(line_p == 1'b1 && line_en == 1'b1, "R5 tail high", int'(line_p), 1);
      chk(in_ready == 1'b0, "R5 tail not ready", int'(in_ready), 0);
    end
    @(negedge clk);
    chk_idle("R5 idle after tail");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1;
    chk_idle("R1 during reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after reset");

    // R7: idle with valid low
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk_idle("R7 idle hold");
    end

    for (int v = 0; v < 6; v++)
      run_frame(int'(VEC[v][19:16]), VEC[v][15:0], 1'b0);

    // R6: valid drops one half-cell after acceptance
    run_frame(1, 16'h0009, 1'b1);
    run_frame(1, 16'h0006, 1'b1);

    // R1: reset mid-frame returns to idle
    @(negedge clk);
    in_valid = 1'b1;
    in_nibble = 4'h3;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk_idle("R1 reset mid-frame");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after mid-frame reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule